// File: doc/BRIEF.md
# Compare to Condition Field Unit

This block compares two register operands, as signed or as unsigned numbers, and places the outcome into one four-bit field of a condition register. The caller supplies the instruction word, both operands, a mode select, the current condition register and the sticky overflow flag. A three-bit index taken from the instruction picks which field is replaced. Field zero is the most significant nibble. The other fields pass through unchanged.

Inputs are accepted on a one-cycle valid strobe. The updated register appears one clock later, together with a done pulse. The unsigned form treats a set length bit in the instruction as an invalid encoding. In that case it raises an illegal flag and returns the incoming register untouched. The signed form does not look at that bit. Register-file reads and exception delivery are handled outside this block.

Top module: `cfu_compare_unit`

## Requirements
- R1: The field index is instruction bits 25..23. Field n is the nibble whose least significant bit is at position 4*(7-n), so index 0 writes bits 31..28 and index 7 writes bits 3..0.
- R2: With in_unsigned = 0 the operands are compared as two's-complement numbers. The selected nibble's upper three bits become 4'b1000 (8) for less-than, 4'b0100 (4) for greater-than and 4'b0010 (2) for equal, with exactly one of the three set.
- R3: With in_unsigned = 1 the operands are compared as unsigned numbers, using the same codes as R2.
- R4: Bit 0 of the written nibble equals in_sticky_ovf as sampled with the strobe.
- R5: On a legal compare, all 28 bits outside the selected nibble equal the in_cond that was sampled with the strobe.
- R6: With in_unsigned = 0, instruction bit 21 has no effect on the result, and out_illegal stays 0.
- R7: With in_unsigned = 1 and instruction bit 21 = 1, out_illegal is 1 for the single result cycle and out_cond equals the sampled in_cond unchanged.
- R8: out_done is 1 exactly in the cycle after each cycle with in_valid = 1, and 0 otherwise. out_cond and out_illegal are valid in that cycle.
- R9: While reset is asserted, out_done = 0, out_illegal = 0 and out_cond = 0.
- R10: In a cycle with no result (out_done = 0), out_cond keeps its previous value and out_illegal is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: sample all inputs this cycle |
| in_instr | input | 32 | Instruction word (field index 25..23, length bit 21) |
| in_opa | input | 32 | First operand |
| in_opb | input | 32 | Second operand |
| in_unsigned | input | 1 | 1 = unsigned compare, 0 = signed compare |
| in_cond | input | 32 | Current condition register |
| in_sticky_ovf | input | 1 | Sticky overflow flag folded into bit 0 of the code |
| out_done | output | 1 | One-cycle pulse marking a result |
| out_cond | output | 32 | Updated condition register |
| out_illegal | output | 1 | Pulse: invalid unsigned encoding, register unchanged |

## Verification
The bench builds the block with a 32-bit data path, eight four-bit fields and the subtractor-based comparator variant. The directed-operator variant is covered by elaboration with defaults. This width puts the sign-boundary operands within reach of the directed cases: the most negative value, all-ones against zero, and neighbours that differ only in the top bit. With these operands the signed and unsigned orderings disagree. Field indices 0 and 7 exercise both ends of the nibble placement. Random operand pairs mixed with equal pairs cover all three codes with and without the sticky flag.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
   localparam int unsigned CODE_W = 4;

   typedef struct packed {
      logic lt;
      logic gt;
      logic eq;
      logic so;
   } cfu_code_t;

   typedef enum logic {
      CMP_SIGNED   = 1'b0,
      CMP_UNSIGNED = 1'b1
   } cfu_mode_e;
endpackage

// File: rtl/cfu_magnitude.sv
// Three-way magnitude comparison, signed or unsigned, one of two structures.
module cfu_magnitude #(
   parameter int unsigned DATA_W    = 32,
   parameter bit          USE_SUB   = 1'b0
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              is_unsigned,
   output logic              lt,
   output logic              gt,
   output logic              eq
);
   localparam int unsigned EXT_W = DATA_W + 1;

   logic [EXT_W-1:0] a_ext;
   logic [EXT_W-1:0] b_ext;

   // one extra bit turns both orderings into one signed ordering
   assign a_ext = {a[DATA_W-1] & ~is_unsigned, a};
   assign b_ext = {b[DATA_W-1] & ~is_unsigned, b};
   assign eq    = (a == b);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("cfu_magnitude: DATA_W must be at least 2");
      end
      if (USE_SUB) begin : g_sub
         logic [EXT_W:0] diff;
         logic [EXT_W:0] a_x;
         logic [EXT_W:0] b_x;
         assign a_x  = {a_ext[EXT_W-1], a_ext};
         assign b_x  = {b_ext[EXT_W-1], b_ext};
         assign diff = a_x - b_x;
         assign lt   = diff[EXT_W];
         assign gt   = ~diff[EXT_W] & ~eq;
      end else begin : g_direct
         assign lt = ($signed(a_ext) < $signed(b_ext));
         assign gt = ($signed(a_ext) > $signed(b_ext));
      end
   endgenerate
endmodule

// File: rtl/cfu_code_gen.sv
// Builds the four-bit result code and the legality decision.
module cfu_code_gen
   import cfu_pkg::*;
#(
   parameter int unsigned INSTR_W = 32,
   parameter int unsigned LEN_BIT = 21
) (
   input  logic               lt,
   input  logic               gt,
   input  logic               eq,
   input  logic               sticky,
   input  cfu_mode_e          mode,
   input  logic [INSTR_W-1:0] instr,
   output cfu_code_t          code,
   output logic               illegal
);
   generate
      if (LEN_BIT >= INSTR_W) begin : g_bad_len
         $error("cfu_code_gen: LEN_BIT outside instruction");
      end
   endgenerate

   always_comb begin
      code    = '0;
      code.lt = lt;
      code.gt = gt & ~lt;
      code.eq = eq & ~lt & ~gt;
      code.so = sticky;
   end

   // only the unsigned form rejects the length bit
   assign illegal = (mode == CMP_UNSIGNED) && instr[LEN_BIT];
endmodule

// File: rtl/cfu_field_merge.sv
// Replaces one nibble of the condition register, counted from the top.
module cfu_field_merge #(
   parameter int unsigned NUM_FIELDS = 8,
   parameter int unsigned FIELD_W    = 4,
   localparam int unsigned IDX_W     = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1,
   localparam int unsigned REG_W     = NUM_FIELDS * FIELD_W
) (
   input  logic [REG_W-1:0]   cond_in,
   input  logic [IDX_W-1:0]   sel,
   input  logic [FIELD_W-1:0] value,
   input  logic               enable,
   output logic [REG_W-1:0]   cond_out
);
   generate
      if ((1 << IDX_W) != NUM_FIELDS) begin : g_bad_fields
         $error("cfu_field_merge: NUM_FIELDS must be a power of two");
      end
      for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
         localparam int unsigned OWNER = NUM_FIELDS - 1 - i;
         logic hit;
         assign hit = enable && (sel == IDX_W'(OWNER));
         assign cond_out[i*FIELD_W +: FIELD_W] =
            hit ? value : cond_in[i*FIELD_W +: FIELD_W];
      end
   endgenerate
endmodule

// File: rtl/cfu_compare_unit.sv
module cfu_compare_unit
   import cfu_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned NUM_FIELDS = 8,
   parameter int unsigned INSTR_W    = 32,
   parameter int unsigned IDX_LSB    = 23,
   parameter int unsigned LEN_BIT    = 21,
   parameter bit          USE_SUB    = 1'b0,
   localparam int unsigned IDX_W     = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1,
   localparam int unsigned REG_W     = NUM_FIELDS * CODE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [INSTR_W-1:0] in_instr,
   input  logic [DATA_W-1:0]  in_opa,
   input  logic [DATA_W-1:0]  in_opb,
   input  logic               in_unsigned,
   input  logic [REG_W-1:0]   in_cond,
   input  logic               in_sticky_ovf,
   output logic               out_done,
   output logic [REG_W-1:0]   out_cond,
   output logic               out_illegal
);
   generate
      if (IDX_LSB + IDX_W > INSTR_W) begin : g_bad_idx
         $error("cfu_compare_unit: field index outside instruction");
      end
   endgenerate

   logic             lt, gt, eq;
   logic             illegal;
   cfu_code_t        code;
   cfu_mode_e        mode;
   logic [IDX_W-1:0] sel;
   logic [REG_W-1:0] merged;

   assign mode = in_unsigned ? CMP_UNSIGNED : CMP_SIGNED;
   assign sel  = in_instr[IDX_LSB +: IDX_W];

   cfu_magnitude #(.DATA_W(DATA_W), .USE_SUB(USE_SUB)) u_mag (
      .a(in_opa), .b(in_opb), .is_unsigned(in_unsigned),
      .lt(lt), .gt(gt), .eq(eq)
   );

   cfu_code_gen #(.INSTR_W(INSTR_W), .LEN_BIT(LEN_BIT)) u_code (
      .lt(lt), .gt(gt), .eq(eq), .sticky(in_sticky_ovf), .mode(mode),
      .instr(in_instr), .code(code), .illegal(illegal)
   );

   cfu_field_merge #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(CODE_W)) u_merge (
      .cond_in(in_cond), .sel(sel), .value(code), .enable(~illegal),
      .cond_out(merged)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_done    <= 1'b0;
         out_illegal <= 1'b0;
         out_cond    <= '0;
      end else begin
         out_done    <= in_valid;
         out_illegal <= in_valid & illegal;
         if (in_valid) out_cond <= merged;
      end
   end
endmodule

// File: rtl/cfu_compare_chk.sv
module cfu_compare_chk #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned NUM_FIELDS = 8,
   parameter int unsigned INSTR_W    = 32,
   parameter int unsigned IDX_LSB    = 23,
   parameter int unsigned LEN_BIT    = 21,
   localparam int unsigned IDX_W     = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1,
   localparam int unsigned REG_W     = NUM_FIELDS * 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [INSTR_W-1:0] in_instr,
   input logic               in_unsigned,
   input logic [REG_W-1:0]   in_cond,
   input logic               in_sticky_ovf,
   input logic               out_done,
   input logic [REG_W-1:0]   out_cond,
   input logic               out_illegal
);
   logic               pv;
   logic [INSTR_W-1:0] pinstr;
   logic               puns;
   logic [REG_W-1:0]   pcond;
   logic               pso;
   logic [REG_W-1:0]   mask;
   logic [3:0]         nib;
   int unsigned        shamt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pv <= 1'b0; pinstr <= '0; puns <= 1'b0; pcond <= '0; pso <= 1'b0;
      end else begin
         pv <= in_valid; pinstr <= in_instr; puns <= in_unsigned;
         pcond <= in_cond; pso <= in_sticky_ovf;
      end
   end

   always_comb begin
      shamt = 4 * (NUM_FIELDS - 1 - int'(pinstr[IDX_LSB +: IDX_W]));
      mask  = REG_W'(4'hF) << shamt;
      nib   = 4'(out_cond >> shamt);
   end

   p_done_after_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_done);
   p_done_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |-> pv);
   p_bad_form_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pv && puns && pinstr[LEN_BIT]) |-> (out_illegal && out_cond == pcond));
   p_illegal_in_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_illegal |-> out_done);
   p_signed_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pv && !puns) |-> !out_illegal);
   p_keep_others_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_done && !out_illegal) |-> (((out_cond ^ pcond) & ~mask) == '0));
   p_one_relation_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_done && !out_illegal) |-> ($countones(nib[3:1]) == 1));
   p_sticky_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_done && !out_illegal) |-> (nib[0] == pso));
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !out_done |-> $stable(out_cond));
endmodule

bind cfu_compare_unit cfu_compare_chk #(
   .DATA_W(DATA_W), .NUM_FIELDS(NUM_FIELDS), .INSTR_W(INSTR_W),
   .IDX_LSB(IDX_LSB), .LEN_BIT(LEN_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
   .in_unsigned(in_unsigned), .in_cond(in_cond), .in_sticky_ovf(in_sticky_ovf),
   .out_done(out_done), .out_cond(out_cond), .out_illegal(out_illegal)
);

// File: tb/sim_cfu_compare_unit.sv
module sim_cfu_compare_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_instr = '0;
   logic [31:0] in_opa = '0;
   logic [31:0] in_opb = '0;
   logic        in_unsigned = 1'b0;
   logic [31:0] in_cond = '0;
   logic        in_sticky_ovf = 1'b0;
   logic        out_done;
   logic [31:0] out_cond;
   logic        out_illegal;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfu_compare_unit #(.USE_SUB(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
      .in_opa(in_opa), .in_opb(in_opb), .in_unsigned(in_unsigned),
      .in_cond(in_cond), .in_sticky_ovf(in_sticky_ovf),
      .out_done(out_done), .out_cond(out_cond), .out_illegal(out_illegal)
   );

   function automatic logic [32:0] model(input logic [31:0] ins, input logic [31:0] a,
                                         input logic [31:0] b, input logic uns,
                                         input logic [31:0] c, input logic so);
      logic [3:0] code;
      int         pos;
      logic [31:0] r;
      if (uns && ins[21]) return {1'b1, c};
      if (uns) code = (a < b) ? 4'h8 : (a > b) ? 4'h4 : 4'h2;
      else     code = ($signed(a) < $signed(b)) ? 4'h8 :
                      ($signed(a) > $signed(b)) ? 4'h4 : 4'h2;
      code[0] = so;
      pos = 4 * (7 - int'(ins[25:23]));
      r = c;
      r[pos +: 4] = code;
      return {1'b0, r};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic run_op(input string req, input logic [31:0] ins, input logic [31:0] a,
                         input logic [31:0] b, input logic uns, input logic [31:0] c,
                         input logic so);
      logic [32:0] e;
      logic [31:0] held;
      e = model(ins, a, b, uns, c, so);
      @(negedge clk);
      in_valid = 1'b1; in_instr = ins; in_opa = a; in_opb = b;
      in_unsigned = uns; in_cond = c; in_sticky_ovf = so;
      @(negedge clk);
      in_valid = 1'b0;
      in_cond = ~c; in_opa = ~a; in_instr = ~ins;
      check({req, " R8 done"}, {31'd0, out_done}, 32'd1);
      check({req, " cond"}, out_cond, e[31:0]);
      check({req, " R7 illegal"}, {31'd0, out_illegal}, {31'd0, e[32]});
      held = out_cond;
      @(negedge clk);
      check("R8 done low", {31'd0, out_done}, 32'd0);
      check("R10 hold", out_cond, held);
      check("R10 illegal low", {31'd0, out_illegal}, 32'd0);
   endtask

   function automatic logic [31:0] mk(input int idx, input logic l);
      logic [31:0] w;
      w = $urandom;
      w[25:23] = 3'(idx);
      w[21] = l;
      return w;
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd1234));
      repeat (2) @(negedge clk);
      check("R9 done", {31'd0, out_done}, 32'd0);
      check("R9 cond", out_cond, 32'd0);
      check("R9 illegal", {31'd0, out_illegal}, 32'd0);
      @(negedge clk) rst_n = 1'b1;

      // R1 field placement at both ends
      run_op("R1 field0", mk(0, 0), 32'd1, 32'd2, 1'b0, 32'h0000_0000, 1'b0);
      run_op("R1 field7", mk(7, 0), 32'd5, 32'd2, 1'b0, 32'hFFFF_FFFF, 1'b0);
      // R2 vs R3 at the sign boundary
      run_op("R2 signed neg", mk(3, 0), 32'h8000_0000, 32'd0, 1'b0, 32'h1234_5678, 1'b0);
      run_op("R3 unsigned big", mk(3, 0), 32'h8000_0000, 32'd0, 1'b1, 32'h1234_5678, 1'b0);
      run_op("R2 all ones", mk(4, 0), 32'hFFFF_FFFF, 32'd0, 1'b0, 32'hA5A5_A5A5, 1'b0);
      run_op("R3 all ones", mk(4, 0), 32'hFFFF_FFFF, 32'd0, 1'b1, 32'hA5A5_A5A5, 1'b0);
      run_op("R2 equal", mk(2, 0), 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0, 32'h0F0F_0F0F, 1'b0);
      // R4 sticky flag
      run_op("R4 sticky", mk(5, 0), 32'd9, 32'd9, 1'b1, 32'h0, 1'b1);
      // R6 signed ignores length bit
      run_op("R6 len bit", mk(6, 1), 32'h7FFF_FFFF, 32'h8000_0000, 1'b0, 32'h5555_5555, 1'b1);
      // R7 unsigned rejects length bit
      run_op("R7 bad form", mk(1, 1), 32'd1, 32'd2, 1'b1, 32'hCAFE_F00D, 1'b0);

      // R8 back-to-back strobes
      @(negedge clk);
      in_valid = 1'b1; in_instr = mk(0, 0); in_opa = 32'd3; in_opb = 32'd4;
      in_unsigned = 1'b1; in_cond = 32'h0; in_sticky_ovf = 1'b0;
      @(negedge clk);
      check("R8 b2b first", out_cond, 32'h8000_0000);
      in_instr = mk(7, 0); in_opa = 32'd4; in_opb = 32'd3; in_cond = 32'h0;
      @(negedge clk);
      in_valid = 1'b0;
      check("R8 b2b second", out_cond, 32'h0000_0004);
      check("R8 b2b done", {31'd0, out_done}, 32'd1);

      // R5 random mix
      for (int i = 0; i < 400; i++) begin
         logic [31:0] a, b;
         a = $urandom;
         b = ($urandom_range(0, 4) == 0) ? a : $urandom;
         if ($urandom_range(0, 3) == 0) b = a ^ 32'h8000_0000;
         run_op("R5 random", mk($urandom_range(0, 7), 1'($urandom_range(0, 1))),
                a, b, 1'($urandom_range(0, 1)), $urandom, 1'($urandom_range(0, 1)));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule